// File: doc/BRIEF.md
# Precise Exception Controller

This block sits beside the hazard logic of a five-stage in-order pipeline and turns two fault flags into a precise trap. Decode reports an unknown opcode through a flag. Execute reports a signed overflow on an add-type operation through a second flag. Each flag arrives with the fetch-address-plus-four of the instruction that raised it. When a fault is taken, the block redirects fetch to a fixed handler entry. It squashes the faulting instruction and everything younger by zeroing their pipeline control, and it records the return hint and a one-bit reason code.

Instructions older than the faulting one retire untouched. If both stages fault in the same cycle, the older instruction wins. That instruction is the one in execute. A taken trap also overrides whatever the hazard unit asked for in that cycle: a load-use stall is dropped, and a branch redirect gives way to the handler address. With no fault, the branch redirect and the stall request pass straight through. Software reads the saved address and subtracts four to find the faulting instruction.

Top module: `exc_ctrl`

## Requirements
- R1: When `ex_ovf_i` is high, the clock edge ending that cycle loads `cause_o` with 1 and `epc_o` with `ex_pc4_i`.
- R2: When `id_undef_i` is high and `ex_ovf_i` is low, the edge loads `cause_o` with 0 and `epc_o` with `id_pc4_i`.
- R3: When both fault flags are high in one cycle, the execute-stage overflow is serviced: `cause_o` becomes 1 and `epc_o` becomes `ex_pc4_i`.
- R4: In any cycle with a fault flag high, `pc_redirect_o` is 1 and `pc_next_o` equals 0x80000180, whatever `branch_taken_i` and `branch_target_i` are.
- R5: On a decode fault alone, `flush_ifid_o` and `flush_idex_o` are 1 and `flush_exmem_o` is 0, so the older instruction in execute proceeds.
- R6: On an overflow, all three flushes `flush_ifid_o`, `flush_idex_o` and `flush_exmem_o` are 1.
- R7: `ex_reg_write_o` is 0 whenever `ex_ovf_i` is 1; otherwise it equals `ex_reg_write_i`, including during a decode fault.
- R8: `stall_o` is 0 in any fault cycle; otherwise it equals `stall_req_i`.
- R9: In cycles without a fault, `epc_o` and `cause_o` keep their values.
- R10: Without a fault, `pc_redirect_o` and `flush_ifid_o` equal `branch_taken_i`, `pc_next_o` equals `branch_target_i` when redirecting, and `flush_idex_o` and `flush_exmem_o` are 0.
- R11: While `rst_ni` is low, `epc_o` is 0 and `cause_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_undef_i | input | 1 | Decode-stage instruction has an unknown opcode |
| id_pc4_i | input | XLEN | Fetch address plus four of the decode-stage instruction |
| ex_ovf_i | input | 1 | Execute-stage add-type operation overflowed |
| ex_pc4_i | input | XLEN | Fetch address plus four of the execute-stage instruction |
| ex_reg_write_i | input | 1 | Register-write control of the execute-stage instruction |
| stall_req_i | input | 1 | Load-use stall request from the hazard unit |
| branch_taken_i | input | 1 | Branch redirect request from decode |
| branch_target_i | input | XLEN | Branch target address |
| stall_o | output | 1 | Stall after fault override |
| ex_reg_write_o | output | 1 | Register-write control after overflow suppression |
| pc_redirect_o | output | 1 | Fetch takes `pc_next_o` at the next edge |
| pc_next_o | output | XLEN | Redirect address |
| flush_ifid_o | output | 1 | Zero the fetch/decode pipeline register |
| flush_idex_o | output | 1 | Zero control in the decode/execute pipeline register |
| flush_exmem_o | output | 1 | Zero control in the execute/memory pipeline register |
| epc_o | output | XLEN | Saved fetch address plus four of the last trapped instruction |
| cause_o | output | 1 | Reason of the last trap, 1 overflow, 0 unknown opcode |

## Verification
The bench sweeps every combination of the two fault flags, the register-write control, the stall request and the branch request, and repeats the sweep with two address bases. Both fault flags high at once separates oldest-first selection from newest-first. A decode fault alone with the write control high shows that the older execute-stage instruction still writes and is not flushed. The fault-free combinations show that the stall and branch requests pass through and that the saved registers hold their values.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [0:0] {
    CAUSE_UNDEF = 1'b0,
    CAUSE_OVF   = 1'b1
  } cause_e;

  // pipeline registers that can be flushed, youngest first
  localparam int unsigned NUM_FL  = 3;
  localparam int unsigned FL_IFID = 0;
  localparam int unsigned FL_IDEX = 1;
  localparam int unsigned FL_EXMEM = 2;

  typedef struct packed {
    logic              take;
    cause_e            cause;
    logic [NUM_FL-1:0] flush;
  } exc_dec_t;
endpackage

// File: rtl/exc_detect.sv
module exc_detect
  import exc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            id_undef_i,
  input  logic [XLEN-1:0] id_pc4_i,
  input  logic            ex_ovf_i,
  input  logic [XLEN-1:0] ex_pc4_i,
  output exc_dec_t        dec_o,
  output logic [XLEN-1:0] pc4_o
);
  // index of the pipeline register holding the faulting instruction
  logic [1:0] fault_lvl;

  always_comb begin
    dec_o.take = ex_ovf_i | id_undef_i;
    // older instruction (execute) wins
    dec_o.cause = ex_ovf_i ? CAUSE_OVF : CAUSE_UNDEF;
    pc4_o       = ex_ovf_i ? ex_pc4_i : id_pc4_i;
    fault_lvl   = ex_ovf_i ? 2'(FL_EXMEM) : 2'(FL_IDEX);
  end

  for (genvar g = 0; g < NUM_FL; g++) begin : g_fl
    assign dec_o.flush[g] = dec_o.take && (2'(g) <= fault_lvl);
  end
endmodule

// File: rtl/exc_regs.sv
module exc_regs
  import exc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  cause_e          cause_i,
  input  logic [XLEN-1:0] pc4_i,
  output logic [XLEN-1:0] epc_o,
  output cause_e          cause_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_o   <= '0;
      cause_o <= CAUSE_UNDEF;
    end else if (take_i) begin
      epc_o   <= pc4_i;
      cause_o <= cause_i;
    end
  end
endmodule

// File: rtl/exc_steer.sv
module exc_steer
  import exc_pkg::*;
#(
  parameter int unsigned     XLEN       = 32,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h8000_0180
) (
  input  exc_dec_t          dec_i,
  input  logic              stall_req_i,
  input  logic              branch_taken_i,
  input  logic [XLEN-1:0]   branch_target_i,
  input  logic              ex_reg_write_i,
  output logic              stall_o,
  output logic              ex_reg_write_o,
  output logic              pc_redirect_o,
  output logic [XLEN-1:0]   pc_next_o,
  output logic [NUM_FL-1:0] flush_o
);
  always_comb begin
    pc_redirect_o  = dec_i.take | branch_taken_i;
    pc_next_o      = dec_i.take ? HANDLER_PC : branch_target_i;
    stall_o        = stall_req_i & ~dec_i.take;
    // faulting instruction sits in execute only on overflow
    ex_reg_write_o = ex_reg_write_i & ~dec_i.flush[FL_EXMEM];
    flush_o        = dec_i.flush;
    flush_o[FL_IFID] = dec_i.flush[FL_IFID] | branch_taken_i;
  end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned     XLEN       = 32,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h8000_0180
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            id_undef_i,
  input  logic [XLEN-1:0] id_pc4_i,
  input  logic            ex_ovf_i,
  input  logic [XLEN-1:0] ex_pc4_i,
  input  logic            ex_reg_write_i,
  input  logic            stall_req_i,
  input  logic            branch_taken_i,
  input  logic [XLEN-1:0] branch_target_i,
  output logic            stall_o,
  output logic            ex_reg_write_o,
  output logic            pc_redirect_o,
  output logic [XLEN-1:0] pc_next_o,
  output logic            flush_ifid_o,
  output logic            flush_idex_o,
  output logic            flush_exmem_o,
  output logic [XLEN-1:0] epc_o,
  output logic            cause_o
);
  exc_dec_t          dec;
  logic [XLEN-1:0]   sel_pc4;
  logic [NUM_FL-1:0] flush;
  cause_e            cause_q;

  exc_detect #(.XLEN(XLEN)) u_detect (
    .id_undef_i (id_undef_i),
    .id_pc4_i   (id_pc4_i),
    .ex_ovf_i   (ex_ovf_i),
    .ex_pc4_i   (ex_pc4_i),
    .dec_o      (dec),
    .pc4_o      (sel_pc4)
  );

  exc_regs #(.XLEN(XLEN)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (dec.take),
    .cause_i (dec.cause),
    .pc4_i   (sel_pc4),
    .epc_o   (epc_o),
    .cause_o (cause_q)
  );

  exc_steer #(.XLEN(XLEN), .HANDLER_PC(HANDLER_PC)) u_steer (
    .dec_i           (dec),
    .stall_req_i     (stall_req_i),
    .branch_taken_i  (branch_taken_i),
    .branch_target_i (branch_target_i),
    .ex_reg_write_i  (ex_reg_write_i),
    .stall_o         (stall_o),
    .ex_reg_write_o  (ex_reg_write_o),
    .pc_redirect_o   (pc_redirect_o),
    .pc_next_o       (pc_next_o),
    .flush_o         (flush)
  );

  assign cause_o       = cause_q;
  assign flush_ifid_o  = flush[FL_IFID];
  assign flush_idex_o  = flush[FL_IDEX];
  assign flush_exmem_o = flush[FL_EXMEM];
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int unsigned     XLEN       = 32,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h8000_0180
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            id_undef_i,
  input logic [XLEN-1:0] id_pc4_i,
  input logic            ex_ovf_i,
  input logic [XLEN-1:0] ex_pc4_i,
  input logic            stall_o,
  input logic            ex_reg_write_o,
  input logic            pc_redirect_o,
  input logic [XLEN-1:0] pc_next_o,
  input logic            flush_ifid_o,
  input logic            flush_idex_o,
  input logic            flush_exmem_o,
  input logic [XLEN-1:0] epc_o,
  input logic            cause_o
);
  p_ovf_save_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_ovf_i |=> (cause_o == 1'b1) && (epc_o == $past(ex_pc4_i)));

  p_undef_save_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_undef_i && !ex_ovf_i) |=> (cause_o == 1'b0) && (epc_o == $past(id_pc4_i)));

  p_handler_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_ovf_i || id_undef_i) |-> pc_redirect_o && (pc_next_o == HANDLER_PC));

  p_undef_flush_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_undef_i && !ex_ovf_i) |-> flush_ifid_o && flush_idex_o && !flush_exmem_o);

  p_ovf_flush_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_ovf_i |-> flush_ifid_o && flush_idex_o && flush_exmem_o);

  p_no_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_ovf_i |-> !ex_reg_write_o);

  p_no_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_ovf_i || id_undef_i) |-> !stall_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ex_ovf_i || id_undef_i) |=> $stable(epc_o) && $stable(cause_o));
endmodule

bind exc_ctrl exc_ctrl_chk #(.XLEN(XLEN), .HANDLER_PC(HANDLER_PC)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .id_undef_i     (id_undef_i),
  .id_pc4_i       (id_pc4_i),
  .ex_ovf_i       (ex_ovf_i),
  .ex_pc4_i       (ex_pc4_i),
  .stall_o        (stall_o),
  .ex_reg_write_o (ex_reg_write_o),
  .pc_redirect_o  (pc_redirect_o),
  .pc_next_o      (pc_next_o),
  .flush_ifid_o   (flush_ifid_o),
  .flush_idex_o   (flush_idex_o),
  .flush_exmem_o  (flush_exmem_o),
  .epc_o          (epc_o),
  .cause_o        (cause_o)
);

// File: tb/exc_ctrl_test.sv
module exc_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] HANDLER = 32'h8000_0180;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        id_undef_i = 1'b0, ex_ovf_i = 1'b0, ex_reg_write_i = 1'b0;
  logic        stall_req_i = 1'b0, branch_taken_i = 1'b0;
  logic [31:0] id_pc4_i = '0, ex_pc4_i = '0, branch_target_i = '0;
  logic        stall_o, ex_reg_write_o, pc_redirect_o, cause_o;
  logic        flush_ifid_o, flush_idex_o, flush_exmem_o;
  logic [31:0] pc_next_o, epc_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_epc = '0;
  logic        exp_cause = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  exc_ctrl uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R11 reset state
    #(CLK_PERIOD*2 + 1);
    chk("R11 epc", epc_o, 32'h0);
    chk("R11 cause", {31'h0, cause_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int base = 0; base < 2; base++) begin
      for (int v = 0; v < 32; v++) begin
        logic ovf, und, rw, stl, br, exc;
        ovf = v[0]; und = v[1]; rw = v[2]; stl = v[3]; br = v[4];
        exc = ovf | und;
        @(negedge clk_i);
        ex_ovf_i        = ovf;
        id_undef_i      = und;
        ex_reg_write_i  = rw;
        stall_req_i     = stl;
        branch_taken_i  = br;
        id_pc4_i        = 32'h0040_1000 + 32'(base) * 32'h0100_0000 + 32'(v) * 8;
        ex_pc4_i        = id_pc4_i - 32'd4;
        branch_target_i = 32'h0000_2000 ^ (32'(v) << 4) ^ 32'(base);
        #1;
        // R4 / R10 redirect
        chk(exc ? "R4 redirect" : "R10 redirect", {31'h0, pc_redirect_o}, {31'h0, exc | br});
        if (exc | br)
          chk(exc ? "R4 target" : "R10 target", pc_next_o, exc ? HANDLER : branch_target_i);
        // R5 / R6 / R10 flushes
        chk(ovf ? "R6 flush_ifid" : (und ? "R5 flush_ifid" : "R10 flush_ifid"),
            {31'h0, flush_ifid_o}, {31'h0, exc | br});
        chk(ovf ? "R6 flush_idex" : (und ? "R5 flush_idex" : "R10 flush_idex"),
            {31'h0, flush_idex_o}, {31'h0, exc});
        chk(ovf ? "R6 flush_exmem" : (und ? "R5 flush_exmem" : "R10 flush_exmem"),
            {31'h0, flush_exmem_o}, {31'h0, ovf});
        chk("R7 reg write", {31'h0, ex_reg_write_o}, {31'h0, rw & ~ovf});
        chk("R8 stall", {31'h0, stall_o}, {31'h0, stl & ~exc});
        if (exc) begin
          exp_cause = ovf;
          exp_epc   = ovf ? ex_pc4_i : id_pc4_i;
        end
        @(posedge clk_i);
        #1;
        chk(ovf && und ? "R3 epc" : (ovf ? "R1 epc" : (und ? "R2 epc" : "R9 epc")), epc_o, exp_epc);
        chk(ovf && und ? "R3 cause" : (ovf ? "R1 cause" : (und ? "R2 cause" : "R9 cause")),
            {31'h0, cause_o}, {31'h0, exp_cause});
      end
    end

    // hold after last fault with idle inputs (R9)
    @(negedge clk_i);
    ex_ovf_i = 1'b0; id_undef_i = 1'b0; branch_taken_i = 1'b0; stall_req_i = 1'b0;
    id_pc4_i = 32'hdead_0004; ex_pc4_i = 32'hbeef_0004;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R9 epc idle", epc_o, exp_epc);
    chk("R9 cause idle", {31'h0, cause_o}, {31'h0, exp_cause});

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule